// File: doc/BRIEF.md
# I2C Controller Event and Interrupt Mask Register Pair

This block keeps the pending-event state of an I2C controller together with a per-bit interrupt enable, and drives one interrupt request line. Four single-cycle pulses from the controller record events:

- transmit error
- receive data discarded because the receiver was busy
- transmit buffer done
- receive buffer closed

Each pulse latches its own bit in the event register. Software reads both registers over a simple single-cycle register bus. It acknowledges an event by writing a one to its bit, and it chooses which events may interrupt by writing the mask register.

The interrupt line is registered. It is high whenever at least one pending event is also enabled, and it stays high until software has acknowledged every enabled pending event. Capture of events does not depend on the mask. A masked event still shows in the event register and starts an interrupt as soon as its enable is set.

Top module: `i2c_evt_irq`

## Requirements
- R1: After reset, and while reset is held, the event register, the mask register and `irq_o` are all zero.
- R2: A high pulse sets its event bit, and a read shows it from the cycle after the pulse. The bit positions are: `evt_rx_done_i` to bit 0, `evt_tx_done_i` to bit 1, `evt_rx_busy_i` to bit 2, `evt_tx_err_i` to bit 4.
- R3: A write to address 0 with a one in an implemented bit position clears that event bit on the following cycle.
- R4: A zero written to address 0 leaves the corresponding event bit unchanged, and the bit holds its value when there is no pulse and no clearing write.
- R5: When a pulse and a clearing write reach the same event bit in the same cycle, the bit ends up set.
- R6: The mask register sits at address 1 and is read/write on bits 0, 1, 2 and 4. A write takes effect on the following cycle.
- R7: Bits 3, 5, 6 and 7 of both registers always read as zero, and writes to them are ignored.
- R8: `irq_o` is a register that holds, one cycle later, the OR over all bits of (event AND mask).
- R9: `irq_o` stays high until every enabled pending event bit has been cleared. A pending event whose mask bit is zero never raises it.
- R10: Writing the mask register never sets or clears an event bit.
- R11: Addresses 2 and 3 read as zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register bus |
| addr_i | input | ADDR_W | Register word address (0 = events, 1 = mask) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| evt_rx_done_i | input | 1 | Receive buffer closed pulse |
| evt_tx_done_i | input | 1 | Transmit buffer done pulse |
| evt_rx_busy_i | input | 1 | Receive data discarded pulse |
| evt_tx_err_i | input | 1 | Transmit error pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle: that each implemented event bit sets, clears and holds as its pulse and the bus write dictate, including the priority of a pulse over a clear; that the interrupt follows (event AND mask) with a one-cycle lag; and that mask writes load the masked data and leave the events alone. Other behaviour only the bench scenarios can show, because it depends on what software observes through the read path. That covers the reserved bits and unmapped addresses reading zero after writes of ones, the interrupt staying high across partial acknowledges and dropping only after the last enabled event is cleared, and masked events waiting in the register until their enable is set.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned REG_W = 8;

  // Bit positions inside the event and mask registers
  localparam int unsigned BIT_RX_DONE = 0;
  localparam int unsigned BIT_TX_DONE = 1;
  localparam int unsigned BIT_RX_BUSY = 2;
  localparam int unsigned BIT_TX_ERR  = 4;

  localparam logic [REG_W-1:0] IMPL_MASK =
    REG_W'((1 << BIT_RX_DONE) | (1 << BIT_TX_DONE) |
           (1 << BIT_RX_BUSY) | (1 << BIT_TX_ERR));

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    logic tx_err;
    logic rx_busy;
    logic tx_done;
    logic rx_done;
  } evt_pulse_t;

  function automatic reg_t pulse_to_vec(evt_pulse_t p);
    reg_t v;
    v = '0;
    v[BIT_RX_DONE] = p.rx_done;
    v[BIT_TX_DONE] = p.tx_done;
    v[BIT_RX_BUSY] = p.rx_busy;
    v[BIT_TX_ERR]  = p.tx_err;
    return v;
  endfunction
endpackage

// File: rtl/i2c_evt_decode.sv
module i2c_evt_decode #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned EVT_ADDR = 0,
  parameter int unsigned MSK_ADDR = 1
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              evt_sel_o,
  output logic              msk_sel_o,
  output logic              evt_we_o,
  output logic              msk_we_o
);
  localparam logic [ADDR_W-1:0] EVT_A = ADDR_W'(EVT_ADDR);
  localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_ADDR);

  assign evt_sel_o = (addr_i == EVT_A);
  assign msk_sel_o = (addr_i == MSK_A);
  assign evt_we_o  = we_i && evt_sel_o;
  assign msk_we_o  = we_i && msk_sel_o;
endmodule

// File: rtl/i2c_evt_bit.sv
// One event flag: the hardware set has priority over a software clear.
module i2c_evt_bit #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  if (IMPL) begin : g_flag
    logic q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_q <= 1'b0;
      else if (set_i) q_q <= 1'b1;
      else if (clr_i) q_q <= 1'b0;
    end
    assign q_o = q_q;
  end else begin : g_rsvd
    logic unused_in;
    assign unused_in = set_i ^ clr_i ^ clk_i ^ rst_ni;
    assign q_o = 1'b0;
  end
endmodule

// File: rtl/i2c_evt_mask.sv
module i2c_evt_mask
  import i2c_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  reg_t wdata_i,
  output reg_t mask_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic m_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   m_q <= 1'b0;
        else if (we_i) m_q <= wdata_i[b];
      end
      assign mask_o[b] = m_q;
    end else begin : g_rsvd
      logic unused_wd;
      assign unused_wd = wdata_i[b];
      assign mask_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_irq_gen.sv
module i2c_evt_irq_gen
  import i2c_evt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  reg_t evt_i,
  input  reg_t mask_i,
  output logic irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(evt_i & mask_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned EVT_ADDR = 0,
  parameter int unsigned MSK_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              evt_rx_done_i,
  input  logic              evt_tx_done_i,
  input  logic              evt_rx_busy_i,
  input  logic              evt_tx_err_i,
  output logic              irq_o
);
  logic evt_sel, msk_sel, evt_we, msk_we;
  reg_t set_vec, clr_vec, evt_q, mask_q;
  evt_pulse_t pulses;

  i2c_evt_decode #(
    .ADDR_W(ADDR_W), .EVT_ADDR(EVT_ADDR), .MSK_ADDR(MSK_ADDR)
  ) u_decode (
    .we_i     (we_i),
    .addr_i   (addr_i),
    .evt_sel_o(evt_sel),
    .msk_sel_o(msk_sel),
    .evt_we_o (evt_we),
    .msk_we_o (msk_we)
  );

  assign pulses  = '{tx_err: evt_tx_err_i, rx_busy: evt_rx_busy_i,
                     tx_done: evt_tx_done_i, rx_done: evt_rx_done_i};
  assign set_vec = pulse_to_vec(pulses);
  assign clr_vec = evt_we ? wdata_i : '0;

  for (genvar b = 0; b < REG_W; b++) begin : g_evt
    i2c_evt_bit #(.IMPL(IMPL_MASK[b])) u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[b]),
      .clr_i (clr_vec[b]),
      .q_o   (evt_q[b])
    );
  end

  i2c_evt_mask u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (msk_we),
    .wdata_i(wdata_i),
    .mask_o (mask_q)
  );

  i2c_evt_irq_gen u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_q),
    .mask_i(mask_q),
    .irq_o (irq_o)
  );

  always_comb begin
    if (evt_sel)      rdata_o = evt_q;
    else if (msk_sel) rdata_o = mask_q;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/i2c_evt_irq_chk.sv
module i2c_evt_irq_chk
  import i2c_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned EVT_ADDR = 0,
  parameter int unsigned MSK_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              evt_rx_done_i,
  input logic              evt_tx_done_i,
  input logic              evt_rx_busy_i,
  input logic              evt_tx_err_i,
  input logic              irq_o,
  input logic [7:0]        evt_q,
  input logic [7:0]        mask_q
);
  logic c_evt_we, c_msk_we;
  logic [7:0] c_set;
  assign c_evt_we = we_i && (addr_i == ADDR_W'(EVT_ADDR));
  assign c_msk_we = we_i && (addr_i == ADDR_W'(MSK_ADDR));
  always_comb begin
    c_set = '0;
    c_set[0] = evt_rx_done_i;
    c_set[1] = evt_tx_done_i;
    c_set[2] = evt_rx_busy_i;
    c_set[4] = evt_tx_err_i;
  end

  // R1
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (evt_q == 8'h00 && mask_q == 8'h00 && !irq_o));

  for (genvar b = 0; b < 8; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      // R2, R5: a pulse always lands, even against a clear
      assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_set[b] |=> evt_q[b]);
      assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_evt_we && wdata_i[b] && !c_set[b]) |=> !evt_q[b]);
      assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!c_set[b] && !(c_evt_we && wdata_i[b])) |=> $stable(evt_q[b]));
    end
  end

  assert_irq_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_q & mask_q)) |=> irq_o);
  assert_irq_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(evt_q & mask_q)) |=> !irq_o);
  assert_mask_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_msk_we |=> (mask_q == ($past(wdata_i) & IMPL_MASK)));
  assert_mask_no_evt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_msk_we && c_set == 8'h00) |=> $stable(evt_q));
endmodule

bind i2c_evt_irq i2c_evt_irq_chk #(
  .ADDR_W(ADDR_W), .EVT_ADDR(EVT_ADDR), .MSK_ADDR(MSK_ADDR)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .evt_rx_done_i(evt_rx_done_i),
  .evt_tx_done_i(evt_tx_done_i),
  .evt_rx_busy_i(evt_rx_busy_i),
  .evt_tx_err_i (evt_tx_err_i),
  .irq_o        (irq_o),
  .evt_q        (evt_q),
  .mask_q       (mask_q)
);

// File: tb/i2c_evt_irq_tb_top.sv
module i2c_evt_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic p_rxd = 1'b0, p_txd = 1'b0, p_rxb = 1'b0, p_txe = 1'b0;
  logic irq;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";

  // reference state
  logic [7:0] m_evt = 8'h00;
  logic [7:0] m_msk = 8'h00;
  logic       m_irq = 1'b0;

  always #4 clk = ~clk;

  i2c_evt_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .evt_rx_done_i(p_rxd), .evt_tx_done_i(p_txd),
    .evt_rx_busy_i(p_rxb), .evt_tx_err_i(p_txe), .irq_o(irq)
  );

  task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // one clock: update the reference at the edge, compare 2 ns later
  task automatic tick();
    logic [7:0] set_v, clr_v;
    @(posedge clk);
    if (!rst_n) begin
      m_evt = 8'h00; m_msk = 8'h00; m_irq = 1'b0;
    end else begin
      set_v = {3'b000, p_txe, 1'b0, p_rxb, p_txd, p_rxd};
      clr_v = (we && addr == 2'd0) ? (wdata & 8'h17) : 8'h00;
      m_irq = |(m_evt & m_msk);
      m_evt = (m_evt & ~clr_v) | set_v;
      if (we && addr == 2'd1) m_msk = wdata & 8'h17;
    end
    #2;
    cmp("rdata", rdata, addr == 2'd0 ? m_evt : (addr == 2'd1 ? m_msk : 8'h00));
    cmp("irq", {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic drive(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic [3:0] p);
    we = w; addr = a; wdata = d;
    {p_txe, p_rxb, p_txd, p_rxd} = p;
    tick();
  endtask

  task automatic idle(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) drive(1'b0, a, 8'h00, 4'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired in %s", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    phase = "R1";
    tick(); tick(); tick();
    @(negedge clk) rst_n = 1'b1;
    idle(2'd0, 1); idle(2'd1, 1);

    phase = "R2";   // each pulse alone, mask zero (R10: capture ignores mask)
    drive(1'b0, 2'd0, 8'h00, 4'b0001);
    drive(1'b0, 2'd0, 8'h00, 4'b0010);
    drive(1'b0, 2'd0, 8'h00, 4'b0100);
    drive(1'b0, 2'd0, 8'h00, 4'b1000);
    idle(2'd0, 2);

    phase = "R4";   // zero write leaves events
    drive(1'b1, 2'd0, 8'h00, 4'h0);
    idle(2'd0, 1);

    phase = "R6";   // mask write, reserved bits read zero (R7)
    drive(1'b1, 2'd1, 8'hFF, 4'h0);
    idle(2'd1, 1);

    phase = "R8";
    idle(2'd0, 2);

    phase = "R9";   // partial clears keep irq, last clear drops it
    drive(1'b1, 2'd0, 8'h01, 4'h0);
    drive(1'b1, 2'd0, 8'h06, 4'h0);
    idle(2'd0, 2);
    drive(1'b1, 2'd0, 8'h10, 4'h0);
    idle(2'd0, 3);

    phase = "R5";   // set and clear collide on bit 1
    drive(1'b1, 2'd0, 8'h02, 4'b0010);
    idle(2'd0, 2);
    drive(1'b1, 2'd0, 8'h02, 4'h0);
    idle(2'd0, 2);

    phase = "R7";   // reserved event bits ignore writes
    drive(1'b1, 2'd0, 8'hE8, 4'h0);
    drive(1'b0, 2'd0, 8'h00, 4'b1000);
    drive(1'b1, 2'd0, 8'hE8, 4'h0);
    idle(2'd0, 2);
    drive(1'b1, 2'd0, 8'hFF, 4'h0);
    idle(2'd0, 2);

    phase = "R10";  // mask write does not touch events
    drive(1'b0, 2'd0, 8'h00, 4'b0101);
    drive(1'b1, 2'd1, 8'h00, 4'h0);
    idle(2'd0, 2);
    drive(1'b1, 2'd1, 8'h01, 4'h0);
    idle(2'd0, 3);

    phase = "R9";   // masked pending event does not raise irq
    drive(1'b1, 2'd0, 8'h01, 4'h0);
    idle(2'd0, 3);
    drive(1'b1, 2'd1, 8'h04, 4'h0);
    idle(2'd0, 3);

    phase = "R11";  // unmapped addresses
    drive(1'b1, 2'd2, 8'hFF, 4'h0);
    drive(1'b1, 2'd3, 8'hFF, 4'h0);
    idle(2'd2, 1); idle(2'd3, 1); idle(2'd0, 1); idle(2'd1, 1);

    phase = "R3";   // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] pr;
      pr = 4'($urandom) & 4'($urandom);
      drive(1'($urandom), 2'($urandom), 8'($urandom), pr);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule